// File: doc/BRIEF.md
# Byte Write Qualification and Bus Control

This block sits between the control pins of a synchronous SRAM with an 18-bit common I/O data bus and its memory core. The bus is split into two 9-bit byte lanes. The block decodes a global write, a byte write enable and one select per lane into one-cycle write strobes for each lane. It captures the write data of the lanes being written on the same edge. It also drives the enable of the tri-state data bus. That enable comes from the asynchronous output enable and the block's own tracking of reads and writes.

Accesses begin on one of two strobes, and the write controls are timed differently for each. A processor-strobe start sees its write controls one clock after the address cycle. A controller-strobe start can become a write in its own first cycle, but only when the processor strobe is inactive. Address generation and the array are handled elsewhere.

Top module: `sram_write_ctrl`

## Requirements
- R1: With global write low (`gw_ni`=0), every lane is strobed on any qualified write edge, whatever `bwe_ni` and `bw_ni` are.
- R2: With `gw_ni`=1, lane i is strobed only when `bwe_ni`=0 and `bw_ni[i]`=0. Lane i owns data bits [9*i+8 : 9*i], so `bw_ni[0]` controls bits 8:0 and `bw_ni[1]` controls bits 17:9.
- R3: A processor start (`cs_ni`=0, `adsp_ni`=0) ignores the write controls of its own cycle. The write controls present on the next edge decide whether, and which lanes, it writes.
- R4: A controller start (`cs_ni`=0, `adsc_ni`=0, `adsp_ni`=1) whose write controls request a write strobes the requested lanes in the cycle after that edge. With no write requested, it starts a read.
- R5: When `adsp_ni` and `adsc_ni` are both low, the controller strobe is ignored, and the access follows the processor-strobe timing of R3.
- R6: While `cs_ni`=1 the processor strobe is ignored: no write follows it.
- R7: `we_o` is high for exactly the cycle after each qualified edge, and is 0 after any edge that was not qualified.
- R8: On a strobed edge, `wdata_o` takes `wdata_i` for the strobed lanes only. Every other lane keeps its previous value.
- R9: `bus_oe_o` is 1 only while `oe_ni`=0 and a read is active. It is forced to 0 in any cycle where a write is being requested for an access, whatever `oe_ni` is.
- R10: Once a write has been detected, `bus_oe_o` stays 0 until a new access starts. A deselect (`cs_ni`=1 with `adsc_ni`=0) also ends an active read.
- R11: During reset `we_o`=0, `wdata_o`=0 and `bus_oe_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Combined chip select, active low |
| adsp_ni | input | 1 | Processor address strobe, active low |
| adsc_ni | input | 1 | Controller address strobe, active low |
| gw_ni | input | 1 | Global write, active low |
| bwe_ni | input | 1 | Byte write enable, active low |
| bw_ni | input | 2 | Per-lane byte select, active low |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| wdata_i | input | 18 | Data from the bus |
| we_o | output | 2 | Per-lane write strobe to the core |
| wdata_o | output | 18 | Captured write data |
| bus_oe_o | output | 1 | Drive enable for the data bus |

## Verification
The decode is driven with a global write alone, a global write with conflicting byte selects, each single-lane select, both selects, and byte selects without the byte write enable. These patterns separate the override path from the per-lane path and expose swapped lanes. Each pattern is applied under both start strobes, under both strobes low together, and while deselected. This shows whether the first-cycle controls are ignored or used at the wrong edge. Output-enable toggling around read starts, writes and deselects shows when the bus is released and when it is retaken.

// File: rtl/sram_write_ctrl_pkg.sv
package sram_write_ctrl_pkg;
  localparam int unsigned DEF_LANES  = 2;
  localparam int unsigned DEF_LANE_W = 9;

  typedef struct packed {
    logic start_p;
    logic start_c;
    logic desel;
  } strobe_dec_t;
endpackage

// File: rtl/wq_lane_decode.sv
module wq_lane_decode #(
  parameter int unsigned LANES = 2
) (
  input  logic             gw_ni,
  input  logic             bwe_ni,
  input  logic [LANES-1:0] bw_ni,
  output logic [LANES-1:0] lane_req_o,
  output logic             any_req_o
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    // global write overrides per-lane selects
    assign lane_req_o[i] = ~gw_ni | (~bwe_ni & ~bw_ni[i]);
  end
  assign any_req_o = |lane_req_o;
endmodule

// File: rtl/wq_seq_ctrl.sv
module wq_seq_ctrl
  import sram_write_ctrl_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic adsp_ni,
  input  logic adsc_ni,
  input  logic any_req_i,
  output logic qual_o,
  output logic wr_now_o,
  output logic pend_o,
  output logic rd_act_o
);
  strobe_dec_t dec;
  logic pend_q, rd_q;

  always_comb begin
    dec.start_p = ~cs_ni & ~adsp_ni;
    dec.start_c = ~cs_ni & adsp_ni & ~adsc_ni;
    dec.desel   = cs_ni & ~adsc_ni;
  end

  // processor start resolves one edge late; controller start resolves now
  assign qual_o   = pend_q | (dec.start_c & any_req_i);
  assign wr_now_o = qual_o & any_req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      rd_q   <= 1'b0;
    end else begin
      pend_q <= dec.start_p;
      if (wr_now_o)                         rd_q <= 1'b0;
      else if (dec.start_p || dec.start_c)  rd_q <= 1'b1;
      else if (dec.desel)                   rd_q <= 1'b0;
    end
  end

  assign pend_o   = pend_q;
  assign rd_act_o = rd_q;
endmodule

// File: rtl/wq_lane_regs.sv
module wq_lane_regs #(
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = 9,
  localparam int unsigned DW    = LANES * LANE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             qual_i,
  input  logic [LANES-1:0] lane_req_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [LANES-1:0] we_o,
  output logic [DW-1:0]    wdata_o
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic              we_q;
    logic [LANE_W-1:0] d_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        we_q <= 1'b0;
        d_q  <= '0;
      end else begin
        we_q <= qual_i & lane_req_i[i];
        if (qual_i && lane_req_i[i]) d_q <= wdata_i[i*LANE_W +: LANE_W];
      end
    end
    assign we_o[i]                      = we_q;
    assign wdata_o[i*LANE_W +: LANE_W]  = d_q;
  end
endmodule

// File: rtl/sram_write_ctrl.sv
module sram_write_ctrl
  import sram_write_ctrl_pkg::*;
#(
  parameter int unsigned LANES  = DEF_LANES,
  parameter int unsigned LANE_W = DEF_LANE_W,
  localparam int unsigned DW    = LANES * LANE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             adsp_ni,
  input  logic             adsc_ni,
  input  logic             gw_ni,
  input  logic             bwe_ni,
  input  logic [LANES-1:0] bw_ni,
  input  logic             oe_ni,
  input  logic [DW-1:0]    wdata_i,
  output logic [LANES-1:0] we_o,
  output logic [DW-1:0]    wdata_o,
  output logic             bus_oe_o
);
  logic [LANES-1:0] lane_req;
  logic any_req, qual, wr_now, pend_q, rd_act;

  wq_lane_decode #(.LANES(LANES)) u_dec (
    .gw_ni      (gw_ni),
    .bwe_ni     (bwe_ni),
    .bw_ni      (bw_ni),
    .lane_req_o (lane_req),
    .any_req_o  (any_req)
  );

  wq_seq_ctrl u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_ni     (cs_ni),
    .adsp_ni   (adsp_ni),
    .adsc_ni   (adsc_ni),
    .any_req_i (any_req),
    .qual_o    (qual),
    .wr_now_o  (wr_now),
    .pend_o    (pend_q),
    .rd_act_o  (rd_act)
  );

  wq_lane_regs #(.LANES(LANES), .LANE_W(LANE_W)) u_lanes (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .qual_i     (qual),
    .lane_req_i (lane_req),
    .wdata_i    (wdata_i),
    .we_o       (we_o),
    .wdata_o    (wdata_o)
  );

  // bus released on any write intent, independent of oe_ni
  assign bus_oe_o = ~oe_ni & rd_act & ~wr_now;
endmodule

// File: rtl/sram_write_ctrl_chk.sv
module sram_write_ctrl_chk #(
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = 9,
  localparam int unsigned DW    = LANES * LANE_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_ni,
  input logic             adsp_ni,
  input logic             adsc_ni,
  input logic             gw_ni,
  input logic             bwe_ni,
  input logic             oe_ni,
  input logic             pend_q,
  input logic [LANES-1:0] we_o,
  input logic [DW-1:0]    wdata_o,
  input logic             bus_oe_o
);
  a_r1_global_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && adsp_ni && !adsc_ni && !gw_ni) |=> (we_o == {LANES{1'b1}}));

  a_r2_no_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gw_ni && bwe_ni) |=> (we_o == '0));

  a_r3_first_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && !adsp_ni && !pend_q) |=> (we_o == '0));

  a_r6_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && !pend_q) |=> (we_o == '0));

  a_r9_oe_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !bus_oe_o);

  a_r9_write_intent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && adsp_ni && !adsc_ni && !gw_ni) |-> !bus_oe_o);

  a_r10_off_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|we_o) |-> !bus_oe_o);

  for (genvar i = 0; i < LANES; i++) begin : g_hold
    a_r8_lane_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !we_o[i] |-> $stable(wdata_o[i*LANE_W +: LANE_W]));
  end
endmodule

bind sram_write_ctrl sram_write_ctrl_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (.*);

// File: tb/sim_sram_write_ctrl.sv
module sim_sram_write_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        cs_ni, adsp_ni, adsc_ni, gw_ni, bwe_ni, oe_ni;
  logic [1:0]  bw_ni;
  logic [17:0] wdata_i;
  logic [1:0]  we_o;
  logic [17:0] wdata_o;
  logic        bus_oe_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference model state
  bit        m_pend, m_rd;
  bit [1:0]  m_we;
  bit [17:0] m_wd;

  always #4 clk_i = ~clk_i;

  sram_write_ctrl u0 (.*);

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit [1:0] req_of(bit gw, bit bwe, bit [1:0] bw);
    bit [1:0] r;
    for (int i = 0; i < 2; i++) r[i] = (gw == 0) || (bwe == 0 && bw[i] == 0);
    return r;
  endfunction

  task automatic cyc(string tag, bit cs, bit p, bit c, bit gw, bit bwe,
                     bit [1:0] bw, bit oe, bit [17:0] d);
    bit [1:0] r;
    bit start_c, qual, wr;
    @(negedge clk_i);
    cs_ni = cs; adsp_ni = p; adsc_ni = c; gw_ni = gw; bwe_ni = bwe;
    bw_ni = bw; oe_ni = oe; wdata_i = d;
    r = req_of(gw, bwe, bw);
    start_c = (cs == 0 && p == 1 && c == 0);
    qual = m_pend || (start_c && r != 0);
    wr = qual && (r != 0);
    #1;
    chk(tag, "bus_oe", 32'(bus_oe_o), 32'(oe == 0 && m_rd && !wr));
    @(posedge clk_i);
    m_we = qual ? r : 2'b00;
    for (int i = 0; i < 2; i++) if (m_we[i]) m_wd[i*9 +: 9] = d[i*9 +: 9];
    if (wr) m_rd = 0;
    else if ((cs == 0 && p == 0) || start_c) m_rd = 1;
    else if (cs == 1 && c == 0) m_rd = 0;
    m_pend = (cs == 0 && p == 0);
    #1;
    chk(tag, "we", 32'(we_o), 32'(m_we));
    chk(tag, "wdata", 32'(wdata_o), 32'(m_wd));
  endtask

  task automatic idle(string tag, bit oe);
    cyc(tag, 1, 1, 1, 1, 1, 2'b11, oe, 18'h0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0;
    cs_ni = 1; adsp_ni = 1; adsc_ni = 1; gw_ni = 1; bwe_ni = 1;
    bw_ni = 2'b11; oe_ni = 0; wdata_i = '1;
    m_pend = 0; m_rd = 0; m_we = 0; m_wd = 0;
    repeat (2) @(negedge clk_i);
    chk("R11", "we", 32'(we_o), 0);
    chk("R11", "wdata", 32'(wdata_o), 0);
    chk("R11", "bus_oe", 32'(bus_oe_o), 0);
    rst_ni = 1'b1;

    // R4: controller start with both lanes selected
    cyc("R4", 0, 1, 0, 1, 0, 2'b00, 1, 18'h2A5A5);
    idle("R7", 1);
    // R2: single lanes
    cyc("R2", 0, 1, 0, 1, 0, 2'b10, 1, 18'h11111);
    cyc("R2", 0, 1, 0, 1, 0, 2'b01, 1, 18'h3CCCC);
    // R2: selects without byte write enable -> read
    cyc("R2", 0, 1, 0, 1, 1, 2'b00, 0, 18'h00F0F);
    idle("R9", 0);
    idle("R9", 1);
    // R1: global write overrides selects
    cyc("R1", 0, 1, 0, 0, 1, 2'b11, 0, 18'h15555);
    cyc("R1", 0, 1, 0, 0, 0, 2'b10, 1, 18'h2AAAA);
    // R10: bus stays off after write
    idle("R10", 0);
    idle("R10", 0);
    // R3: first-cycle write controls ignored, next-cycle ones used
    cyc("R3", 0, 0, 1, 0, 0, 2'b00, 0, 18'h3FFFF);
    cyc("R3", 1, 1, 1, 1, 0, 2'b10, 0, 18'h01234);
    idle("R3", 0);
    // R3: processor read then bus driven
    cyc("R3", 0, 0, 1, 1, 1, 2'b11, 0, 18'h0);
    idle("R9", 0);
    idle("R9", 0);
    // R10: deselect ends read
    cyc("R10", 1, 1, 0, 1, 1, 2'b11, 0, 18'h0);
    idle("R10", 0);
    // R5: both strobes low -> controller ignored
    cyc("R5", 0, 0, 0, 0, 0, 2'b00, 0, 18'h2BEEF);
    cyc("R5", 1, 1, 1, 1, 1, 2'b11, 0, 18'h1CAFE);
    idle("R5", 0);
    // R6: processor strobe while deselected
    cyc("R6", 1, 0, 1, 0, 0, 2'b00, 0, 18'h3AAAA);
    cyc("R6", 1, 1, 1, 0, 0, 2'b00, 0, 18'h05555);
    idle("R6", 1);
    // R9: write intent in follow-up cycle drops the bus at once
    cyc("R9", 0, 0, 1, 1, 1, 2'b11, 0, 18'h0);
    cyc("R9", 1, 1, 1, 0, 1, 2'b11, 0, 18'h12345);
    idle("R9", 0);
    // R8: back-to-back lane writes keep other lane
    cyc("R8", 0, 1, 0, 1, 0, 2'b01, 1, 18'h3F00F);
    cyc("R8", 0, 1, 0, 1, 0, 2'b10, 1, 18'h000F0);
    idle("R7", 1);
    idle("R7", 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule